// File: doc/BRIEF.md
# Eight-Input Interrupt Controller Register Interface

This block sits between a processor bus and the core of an eight-input interrupt controller. The processor reaches it through two byte-wide ports picked by a single address bit, qualified by a select line and separate read and write strobes that are sampled on the clock edge. A multi-word start-up sequence loads the controller's configuration: the trigger style, single or cascaded operation, the upper bits of the interrupt vector, and the fourth-word options (processor mode, automatic end-of-interrupt, slave role, buffered bus, nested mode). How many words that sequence takes depends on flag bits carried in its first word.

Once configured, writes are sorted by fixed bit patterns. A write to the high port loads the mask. A write to the low port is either a priority/end-of-interrupt command, which is handed to the core as a one-cycle pulse with its opcode and level, or a read-control word that picks the register the low port returns, toggles special masking, or arms a poll. Priority resolution lives in the core; the core supplies the request register, the in-service register and the poll answer on input ports, and this block only steers them onto the read bus.

Top module: `irq_regif`

## Requirements
- R1: After reset, init_done, mask, special_mask, poll_active, cmd_valid and every configuration output are 0, and a low-port read returns irq_req.
- R2: A low-port write with data bit 4 set starts the start-up sequence from any state: init_done drops, mask clears, low-port reads go back to irq_req, special mask and any pending poll clear, the fourth-word fields clear, and the word's bit 0 (fourth word follows), bit 1 (single controller) and bit 3 (trig_level) are captured.
- R3: The first high-port write after the starting word sets vec_base to data bits 7..3.
- R4: A third high-port word is consumed only when the single bit is clear; when it is set, the fourth word follows the second directly; the sequence ends (init_done = 1) after the last expected word, and with no fourth word the fourth-word fields stay 0.
- R5: The fourth word sets mode_86 from bit 0, auto_eoi from bit 1, slave_sel from bit 2, buf_mode from bit 3 and nest_mode from bit 4.
- R6: With init_done = 1 a high-port write loads mask; a high-port read returns mask; high-port writes made before or during the sequence leave mask unchanged.
- R7: With init_done = 1, a low-port write with bits 4 and 3 both clear raises cmd_valid for exactly the following cycle, with cmd_code = bits 7..5 and cmd_level = bits 2..0.
- R8: With init_done = 1, a low-port write with bit 4 clear and bit 3 set is a read-control word: bits 1..0 = 10 select irq_req and 11 select irq_svc for later low-port reads, 00 or 01 keep the selection.
- R9: In a read-control word, bits 6..5 = 11 set special_mask, 10 clear it, 00 or 01 keep it.
- R10: Bit 2 of a read-control word arms a poll (poll_active = 1); the next read of either port returns poll_code instead of the usual register and clears poll_active.
- R11: Before init_done is 1, low-port writes with bit 4 clear give no cmd_valid and change neither the read selection nor special_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel | input | 1 | Bus select, active high |
| addr | input | 1 | Port select: 0 low port, 1 high port |
| wr_stb | input | 1 | Write strobe, sampled on the clock edge |
| rd_stb | input | 1 | Read strobe, sampled on the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while sel and rd_stb are high |
| irq_req | input | 8 | Request register from the core |
| irq_svc | input | 8 | In-service register from the core |
| poll_code | input | 8 | Poll answer from the core |
| trig_level | output | 1 | 1 = level triggered, 0 = edge triggered |
| single_mode | output | 1 | 1 = single controller, 0 = cascaded |
| vec_base | output | 5 | Upper vector bits |
| mode_86 | output | 1 | Processor mode bit from the fourth word |
| auto_eoi | output | 1 | Automatic end-of-interrupt enable |
| slave_sel | output | 1 | 1 = slave role |
| buf_mode | output | 1 | Buffered bus |
| nest_mode | output | 1 | Special fully nested mode |
| init_done | output | 1 | Start-up sequence complete |
| mask | output | 8 | Interrupt mask register |
| special_mask | output | 1 | Special mask mode active |
| poll_active | output | 1 | Poll armed, waiting for a read |
| cmd_valid | output | 1 | One-cycle priority/end-of-interrupt command pulse |
| cmd_code | output | 3 | Command opcode |
| cmd_level | output | 3 | Command level |

## Verification
Every cycle the assertions check that a starting word always lands the sequencer in its second-word state, that a single-controller setup never enters the third-word state, that mask holds still across high-port writes made before the sequence ends, that no command pulse follows a cycle without init_done, and that any read clears an armed poll. Only the bench scenarios can show the field positions of each word, the different sequence lengths for single, cascaded, with and without a fourth word, the read-selection and special-mask encodings including their hold codes, and the values that actually come back on rdata for each read source.

// File: rtl/irq_regif_pkg.sv
package irq_regif_pkg;
  localparam int DATA_W = 8;
  localparam int VB_LSB = 3;
  localparam int VB_W   = DATA_W - VB_LSB;
  localparam int CMD_W  = 3;

  typedef enum logic [2:0] {
    ST_UNINIT = 3'd0,
    ST_W2     = 3'd1,
    ST_W3     = 3'd2,
    ST_W4     = 3'd3,
    ST_READY  = 3'd4
  } seq_state_e;

  typedef enum logic {
    RS_REQ = 1'b0,
    RS_SVC = 1'b1
  } rd_src_e;

  typedef struct packed {
    logic            need_w4;
    logic            single;
    logic            level;
    logic [VB_W-1:0] vbase;
    logic            m86;
    logic            aeoi;
    logic            slave;
    logic            bufd;
    logic            nest;
  } cfg_t;
endpackage

// File: rtl/irq_init_seq.sv
module irq_init_seq
  import irq_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output cfg_t              cfg,
  output logic              init_done
);
  seq_state_e st_q, st_d;
  cfg_t       cfg_q, cfg_d;
  logic       seq_en;

  assign seq_en = start | wr_hi;

  always_comb begin
    st_d  = st_q;
    cfg_d = cfg_q;
    if (start) begin
      st_d          = ST_W2;
      cfg_d         = '0;
      cfg_d.need_w4 = wdata[0];
      cfg_d.single  = wdata[1];
      cfg_d.level   = wdata[3];
    end else if (wr_hi) begin
      unique case (st_q)
        ST_W2: begin
          cfg_d.vbase = wdata[DATA_W-1:VB_LSB];
          if (!cfg_q.single)       st_d = ST_W3;
          else if (cfg_q.need_w4)  st_d = ST_W4;
          else                     st_d = ST_READY;
        end
        ST_W3: st_d = cfg_q.need_w4 ? ST_W4 : ST_READY;
        ST_W4: begin
          cfg_d.m86   = wdata[0];
          cfg_d.aeoi  = wdata[1];
          cfg_d.slave = wdata[2];
          cfg_d.bufd  = wdata[3];
          cfg_d.nest  = wdata[4];
          st_d        = ST_READY;
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_UNINIT;
      cfg_q <= '0;
    end else if (seq_en) begin
      st_q  <= st_d;
      cfg_q <= cfg_d;
    end
  end

  assign cfg       = cfg_q;
  assign init_done = (st_q == ST_READY);

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (st_q == ST_W2));

  assert_single_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_W2 && wr_hi && !start && cfg_q.single) |=> (st_q != ST_W3));
endmodule

// File: rtl/irq_op_decode.sv
module irq_op_decode
  import irq_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              init_done,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              rd_any,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask,
  output rd_src_e           rsel,
  output logic              smm,
  output logic              poll_pend,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_code,
  output logic [CMD_W-1:0]  cmd_level
);
  logic              op_word, cmd_word, ctl_word, mask_wr;
  logic [DATA_W-1:0] mask_q, mask_d;
  rd_src_e           rsel_q, rsel_d;
  logic              smm_q, smm_d, poll_q, poll_d;
  logic              cv_q;
  logic [CMD_W-1:0]  code_q, lvl_q;

  assign op_word  = wr_lo & ~wdata[4] & init_done;
  assign cmd_word = op_word & ~wdata[3];
  assign ctl_word = op_word &  wdata[3];
  assign mask_wr  = wr_hi & init_done;

  always_comb begin
    mask_d = mask_q;
    rsel_d = rsel_q;
    smm_d  = smm_q;
    poll_d = poll_q;
    if (start) begin
      mask_d = '0;
      rsel_d = RS_REQ;
      smm_d  = 1'b0;
      poll_d = 1'b0;
    end else begin
      if (mask_wr) mask_d = wdata;
      if (rd_any)  poll_d = 1'b0;
      if (ctl_word) begin
        if (wdata[1]) rsel_d = wdata[0] ? RS_SVC : RS_REQ;
        if (wdata[6]) smm_d  = wdata[5];
        if (wdata[2]) poll_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      rsel_q <= RS_REQ;
      smm_q  <= 1'b0;
      poll_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      rsel_q <= rsel_d;
      smm_q  <= smm_d;
      poll_q <= poll_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv_q   <= 1'b0;
      code_q <= '0;
      lvl_q  <= '0;
    end else begin
      cv_q <= cmd_word;
      if (cmd_word) begin
        code_q <= wdata[7:5];
        lvl_q  <= wdata[2:0];
      end
    end
  end

  assign mask      = mask_q;
  assign rsel      = rsel_q;
  assign smm       = smm_q;
  assign poll_pend = poll_q;
  assign cmd_valid = cv_q;
  assign cmd_code  = code_q;
  assign cmd_level = lvl_q;

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !init_done && !start) |=> $stable(mask_q));

  assert_no_cmd_early_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |=> !cv_q);

  assert_poll_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && poll_q && !(ctl_word && wdata[2])) |=> !poll_q);
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
  import irq_regif_pkg::*;
(
  input  logic              addr,
  input  logic              poll_pend,
  input  rd_src_e           rsel,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] irq_req,
  input  logic [DATA_W-1:0] irq_svc,
  input  logic [DATA_W-1:0] poll_code,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    if (poll_pend)          rdata = poll_code;
    else if (addr)          rdata = mask;
    else if (rsel == RS_SVC) rdata = irq_svc;
    else                    rdata = irq_req;
  end
endmodule

// File: rtl/irq_regif.sv
module irq_regif
  import irq_regif_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        addr,
  input  logic        wr_stb,
  input  logic        rd_stb,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [7:0]  irq_req,
  input  logic [7:0]  irq_svc,
  input  logic [7:0]  poll_code,
  output logic        trig_level,
  output logic        single_mode,
  output logic [4:0]  vec_base,
  output logic        mode_86,
  output logic        auto_eoi,
  output logic        slave_sel,
  output logic        buf_mode,
  output logic        nest_mode,
  output logic        init_done,
  output logic [7:0]  mask,
  output logic        special_mask,
  output logic        poll_active,
  output logic        cmd_valid,
  output logic [2:0]  cmd_code,
  output logic [2:0]  cmd_level
);
  logic    rst_meta, rst_sync;
  logic    wr_lo, wr_hi, rd_any, start;
  cfg_t    cfg;
  rd_src_e rsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign wr_lo  = sel & wr_stb & ~addr;
  assign wr_hi  = sel & wr_stb &  addr;
  assign rd_any = sel & rd_stb;
  assign start  = wr_lo & wdata[4];

  irq_init_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_sync),
    .start     (start),
    .wr_hi     (wr_hi),
    .wdata     (wdata),
    .cfg       (cfg),
    .init_done (init_done)
  );

  irq_op_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_sync),
    .start     (start),
    .init_done (init_done),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .rd_any    (rd_any),
    .wdata     (wdata),
    .mask      (mask),
    .rsel      (rsel),
    .smm       (special_mask),
    .poll_pend (poll_active),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_level (cmd_level)
  );

  irq_rd_mux u_mux (
    .addr      (addr),
    .poll_pend (poll_active),
    .rsel      (rsel),
    .mask      (mask),
    .irq_req   (irq_req),
    .irq_svc   (irq_svc),
    .poll_code (poll_code),
    .rdata     (rdata)
  );

  assign trig_level  = cfg.level;
  assign single_mode = cfg.single;
  assign vec_base    = cfg.vbase;
  assign mode_86     = cfg.m86;
  assign auto_eoi    = cfg.aeoi;
  assign slave_sel   = cfg.slave;
  assign buf_mode    = cfg.bufd;
  assign nest_mode   = cfg.nest;
endmodule

// File: tb/tb_irq_regif.sv
`timescale 1ns/1ps
module tb_irq_regif;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel = 1'b0, addr = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] irq_req = 8'h5A, irq_svc = 8'h81, poll_code = 8'h83;
  logic       trig_level, single_mode, mode_86, auto_eoi, slave_sel;
  logic       buf_mode, nest_mode, init_done, special_mask, poll_active, cmd_valid;
  logic [4:0] vec_base;
  logic [7:0] mask;
  logic [2:0] cmd_code, cmd_level;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  irq_regif dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .wdata(wdata), .rdata(rdata), .irq_req(irq_req),
    .irq_svc(irq_svc), .poll_code(poll_code), .trig_level(trig_level),
    .single_mode(single_mode), .vec_base(vec_base), .mode_86(mode_86),
    .auto_eoi(auto_eoi), .slave_sel(slave_sel), .buf_mode(buf_mode),
    .nest_mode(nest_mode), .init_done(init_done), .mask(mask),
    .special_mask(special_mask), .poll_active(poll_active),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_level(cmd_level)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr_stb = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr_stb = 1'b0; wdata = 8'h00;
  endtask

  // driver: pushes the expected read value, then performs the read
  task automatic rd(input logic a, input logic [7:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    sel = 1'b1; rd_stb = 1'b1; addr = a;
    @(negedge clk);
    sel = 1'b0; rd_stb = 1'b0;
  endtask

  // monitor: pops and compares while the read strobe is up
  always @(negedge clk) begin
    #2;
    if (sel && rd_stb) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard: unexpected read, actual %0h expected none", rdata);
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %0h expected %0h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(init_done, 0, "R1 init_done");
    chk(mask, 0, "R1 mask");
    chk(cmd_valid, 0, "R1 cmd_valid");
    chk({special_mask, poll_active}, 0, "R1 smm/poll");
    chk({trig_level, single_mode, vec_base, mode_86, auto_eoi, slave_sel, buf_mode, nest_mode}, 0, "R1 config");
    rd(1'b0, 8'h5A, "R1 low read = requests");

    // R6 high write before any start-up word is ignored
    wr(1'b1, 8'hFF);
    rd(1'b1, 8'h00, "R6 mask untouched before init");
    // R11 low op word before init
    wr(1'b0, 8'h0B);
    chk(cmd_valid, 0, "R11 no pulse before init");
    rd(1'b0, 8'h5A, "R11 selection unchanged before init");

    // single controller with fourth word: 0x1B = start, level, single, need4
    wr(1'b0, 8'h1B);
    chk(init_done, 0, "R2 init_done low");
    chk({trig_level, single_mode}, 2'b11, "R2 level/single");
    wr(1'b1, 8'h48);
    chk(vec_base, 5'd9, "R3 vector base");
    chk(init_done, 0, "R4 waits for fourth word");
    wr(1'b1, 8'h1F);
    chk(init_done, 1, "R4 done after fourth (no third)");
    chk({mode_86, auto_eoi, slave_sel, buf_mode, nest_mode}, 5'b11111, "R5 fourth-word fields");
    chk(vec_base, 5'd9, "R4 vector base kept");

    // R6 mask load
    wr(1'b1, 8'hA5);
    chk(mask, 8'hA5, "R6 mask port");
    rd(1'b1, 8'hA5, "R6 high read returns mask");

    // R7 command word 0x63: code 3, level 3
    wr(1'b0, 8'h63);
    chk(cmd_valid, 1, "R7 pulse");
    chk({cmd_code, cmd_level}, {3'd3, 3'd3}, "R7 code/level");
    @(negedge clk);
    chk(cmd_valid, 0, "R7 pulse one cycle");
    wr(1'b0, 8'hE5);
    chk({cmd_valid, cmd_code, cmd_level}, {1'b1, 3'd7, 3'd5}, "R7 second command");

    // R8 read selection
    wr(1'b0, 8'h0B);
    chk(cmd_valid, 0, "R8 control word is not a command");
    rd(1'b0, 8'h81, "R8 select in-service");
    wr(1'b0, 8'h08);
    rd(1'b0, 8'h81, "R8 code 00 holds");
    wr(1'b0, 8'h09);
    rd(1'b0, 8'h81, "R8 code 01 holds");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h5A, "R8 select requests");

    // R9 special mask
    wr(1'b0, 8'h68);
    chk(special_mask, 1, "R9 set");
    wr(1'b0, 8'h28);
    chk(special_mask, 1, "R9 code 01 holds");
    wr(1'b0, 8'h48);
    chk(special_mask, 0, "R9 clear");

    // R10 poll
    wr(1'b0, 8'h0C);
    chk(poll_active, 1, "R10 poll armed");
    rd(1'b1, 8'h83, "R10 poll overrides high read");
    chk(poll_active, 0, "R10 poll cleared by read");
    rd(1'b1, 8'hA5, "R10 mask back after poll");
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h83, "R10 poll overrides low read");
    rd(1'b0, 8'h5A, "R10 selection back after poll");

    // R2 restart from ready: leave in-service selected and special mask set first
    wr(1'b0, 8'h0B);
    wr(1'b0, 8'h6C);
    wr(1'b0, 8'h10);
    chk(init_done, 0, "R2 restart drops init_done");
    chk(mask, 0, "R2 mask cleared");
    chk({special_mask, poll_active}, 0, "R2 smm/poll cleared");
    chk({trig_level, single_mode, mode_86, auto_eoi, slave_sel, buf_mode, nest_mode}, 0, "R2 fields cleared");
    rd(1'b0, 8'h5A, "R2 selection back to requests");
    wr(1'b0, 8'h20);
    chk(cmd_valid, 0, "R11 no pulse during init");
    // cascaded, no fourth word: second then third word
    wr(1'b1, 8'hF8);
    chk(vec_base, 5'd31, "R3 vector base max");
    chk(init_done, 0, "R4 cascaded waits for third");
    wr(1'b1, 8'h00);
    chk(init_done, 1, "R4 done after third");
    chk({mode_86, auto_eoi, slave_sel, buf_mode, nest_mode}, 0, "R4 no fourth word fields zero");
    chk(mask, 0, "R6 sequence words not masks");

    // cascaded with fourth word
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h20);
    wr(1'b1, 8'h07);
    chk(init_done, 0, "R4 cascaded with fourth after third");
    wr(1'b1, 8'h02);
    chk(init_done, 1, "R4 done after fourth");
    chk({mode_86, auto_eoi, slave_sel, buf_mode, nest_mode}, 5'b01000, "R5 auto_eoi only");
    chk(vec_base, 5'd4, "R3 vector base 4");

    repeat (2) @(negedge clk);
    chk(exp_q.size(), 0, "scoreboard drained");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule